// File: doc/BRIEF.md
# ADC conversion control registers

This block is the register front end of a multi-engine analog-to-digital converter. Software talks to it over a simple single-cycle register bus with byte lanes. Setting a bit in the engine-enable register launches one conversion on that engine. The block then clears the bit by itself when the converter reports completion, so software can poll the bit to learn when the conversion is done. There are three engines: auxiliary, battery and touch.

Each completion, and each pen or sleep event reported by the touch front end, sets a sticky bit in an interrupt status register. Software clears a status bit by writing a one to it. A mask register gates the status bits onto a single interrupt line; a one in the mask blocks that source. The 12-bit auxiliary and battery results are latched into read-only data registers when their conversions complete. A configuration register drives the auxiliary input select and the low-reference battery mode. A power-down bit sits in the enable register beside the engine bits.

Each engine has a handshake with the converter. The block sends a one-cycle start pulse, and the converter returns a one-cycle done pulse, with the result word valid in that same cycle.

Top module: `adc_ctl_regs`

## Requirements
- R1: After reset, the enable register (offset 0x00) reads 0, the configuration register (0x04) reads 0, the mask register (0x08) reads 0xFF, the status register (0x0C) reads 0 and both data registers read 0. In the same state, irq_o, eng_start_o and pwr_down_o are 0.
- R2: Engine bits in the enable register are bit 0 (aux), bit 1 (battery) and bit 2 (touch). A write that sets an engine bit which was 0 makes that bit read 1, and raises that engine's eng_start_o for exactly the one cycle after the write. Writing 1 to a bit that is already 1 produces no new pulse.
- R3: A done pulse on an engine whose enable bit is 1 clears that bit. A done pulse on an engine whose bit is 0 is ignored: it sets no status bit and latches no result.
- R4: An accepted completion sets status bit n for engine n. The pen event inputs pen_evt_i[0..3] (pen down, pen up, pen down while asleep, sleep) set status bits 3, 4, 5 and 7. Status bit 6 always reads 0.
- R5: An accepted aux completion latches aux_res_i into the register at offset 0x20. An accepted battery completion latches bat_res_i into the register at 0x1C. Both read as a 12-bit value in bits [11:0] with the upper bits 0. Bus writes to either data register have no effect.
- R6: Writing to the status register (0x0C) clears every bit written as 1 and leaves the others unchanged, so writing 0xFF clears all sources. A status bit that hardware sets in the same cycle as a software clear of that bit stays set.
- R7: The mask register (0x08) holds 8 bits, and a 1 masks the matching source. irq_o is high exactly when some status bit is set and its mask bit is 0. With the mask at 0xFB, only the touch source (bit 2) can raise irq_o.
- R8: A write that clears the enable bit of a running engine aborts that conversion. A done pulse in that same cycle or afterwards sets no status bit and latches no result.
- R9: Configuration bits [1:0] drive aux_sel_o and bit 4 drives bat_lowref_o; these bits read back, and all other configuration bits read 0. Enable-register bit 7 drives pwr_down_o, reads back, and neither starts nor stops any engine.
- R10: Only writes with wr_be_i[0] set change any register, because every writable field lives in byte 0. Writes that enable only other lanes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_be_i | input | 4 | Byte-lane enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt: any unmasked status bit |
| eng_start_o | output | 3 | One-cycle start pulse per engine |
| eng_done_i | input | 3 | One-cycle completion pulse per engine |
| aux_res_i | input | 12 | Aux result, valid with eng_done_i[0] |
| bat_res_i | input | 12 | Battery result, valid with eng_done_i[1] |
| pen_evt_i | input | 4 | Pen down, pen up, pen down asleep, sleep events |
| aux_sel_o | output | 2 | Aux input select |
| bat_lowref_o | output | 1 | Low-reference battery mode |
| pwr_down_o | output | 1 | Converter power-down request |

## Verification
The bound checker watches four things on every cycle:
- A start pulse only appears on an engine that is now busy, and it never repeats in the next cycle.
- An accepted completion both clears its engine bit and leaves its status bit set, even when a status clear lands in the same cycle.
- An abort never produces a status bit.
- A fully masked status never raises the interrupt, and status bit 6 never appears.

Some behaviours show only in the bench's scenarios, checked against its reference model:
- The exact result words in the data registers, and the rule that data-register writes are ignored.
- Done pulses on idle engines.
- Byte-lane filtering.
- The configuration and power-down readback.
- The single-source touch mask.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int unsigned REG_ADDR_W = 6;
  localparam int unsigned IRQ_W      = 8;

  localparam logic [REG_ADDR_W-1:0] OFS_ENA = 6'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_CFG = 6'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_MSK = 6'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_STA = 6'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_BAT = 6'h1C;
  localparam logic [REG_ADDR_W-1:0] OFS_AUX = 6'h20;

  localparam int unsigned ENG_AUX = 0;
  localparam int unsigned ENG_BAT = 1;

  localparam int unsigned BIT_PEN_DN     = 3;
  localparam int unsigned BIT_PEN_UP     = 4;
  localparam int unsigned BIT_PEN_DN_SLP = 5;
  localparam int unsigned BIT_SLEEP      = 7;
  localparam int unsigned BIT_PWR_DN     = 7;
  localparam int unsigned BIT_LOWREF     = 4;
endpackage

// File: rtl/adc_eng_ctl.sv
module adc_eng_ctl #(
  parameter int unsigned N_ENG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_ENG-1:0] wbits_i,
  input  logic [N_ENG-1:0] done_i,
  output logic [N_ENG-1:0] en_o,
  output logic [N_ENG-1:0] start_o,
  output logic [N_ENG-1:0] cmpl_o
);
  logic [N_ENG-1:0] en_q, en_d, go, start_q;

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    // a write that clears the bit aborts; done then counts for nothing
    assign cmpl_o[g] = en_q[g] & done_i[g] & (~wr_i | wbits_i[g]);
    assign go[g]     = wr_i & wbits_i[g] & ~en_q[g];
    always_comb begin
      if (cmpl_o[g])  en_d[g] = 1'b0;
      else if (wr_i)  en_d[g] = wbits_i[g];
      else            en_d[g] = en_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      start_q <= '0;
    end else begin
      en_q    <= en_d;
      start_q <= go;
    end
  end

  assign en_o    = en_q;
  assign start_o = start_q;
endmodule

// File: rtl/adc_irq_ctl.sv
module adc_irq_ctl #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] set_i,
  input  logic [IRQ_W-1:0] clr_i,
  input  logic             mask_wr_i,
  input  logic [IRQ_W-1:0] mask_wdata_i,
  output logic [IRQ_W-1:0] stat_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~clr_i) | set_i;  // set beats clear
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/adc_res_regs.sv
module adc_res_regs #(
  parameter int unsigned N_RES = 2,
  parameter int unsigned RES_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_RES-1:0]            load_i,
  input  logic [N_RES-1:0][RES_W-1:0] res_i,
  output logic [N_RES-1:0][RES_W-1:0] res_o
);
  for (genvar g = 0; g < N_RES; g++) begin : g_res
    logic [RES_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= '0;
      else if (load_i[g]) q <= res_i[g];
    end
    assign res_o[g] = q;
  end
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter int unsigned N_ENG  = 3,
  parameter int unsigned RES_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W/8-1:0]   wr_be_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o,
  output logic [N_ENG-1:0]      eng_start_o,
  input  logic [N_ENG-1:0]      eng_done_i,
  input  logic [RES_W-1:0]      aux_res_i,
  input  logic [RES_W-1:0]      bat_res_i,
  input  logic [3:0]            pen_evt_i,
  output logic [1:0]            aux_sel_o,
  output logic                  bat_lowref_o,
  output logic                  pwr_down_o
);
  localparam int unsigned N_RES = 2;
  localparam int unsigned PAD_W = DATA_W - RES_W;

  logic             lane0, wr_ena, wr_cfg, wr_msk, wr_sta;
  logic [7:0]       wb;
  logic [N_ENG-1:0] en_q, cmpl;
  logic [IRQ_W-1:0] set_v, clr_v, stat_q, mask_q;
  logic [1:0]       sel_q;
  logic             low_q, pd_q;
  logic [N_RES-1:0][RES_W-1:0] res_in, res_q;
  logic [7:0]       ena_rd;
  logic             unused_hi;

  assign lane0  = wr_en_i & wr_be_i[0];
  assign wb     = wdata_i[7:0];
  assign wr_ena = lane0 && (addr_i == OFS_ENA);
  assign wr_cfg = lane0 && (addr_i == OFS_CFG);
  assign wr_msk = lane0 && (addr_i == OFS_MSK);
  assign wr_sta = lane0 && (addr_i == OFS_STA);
  assign unused_hi = ^{wdata_i[DATA_W-1:8], wr_be_i[DATA_W/8-1:1]};

  adc_eng_ctl #(.N_ENG(N_ENG)) u_eng (
    .clk_i, .rst_ni,
    .wr_i    (wr_ena),
    .wbits_i (wb[N_ENG-1:0]),
    .done_i  (eng_done_i),
    .en_o    (en_q),
    .start_o (eng_start_o),
    .cmpl_o  (cmpl)
  );

  always_comb begin
    set_v                 = '0;
    set_v[N_ENG-1:0]      = cmpl;
    set_v[BIT_PEN_DN]     = pen_evt_i[0];
    set_v[BIT_PEN_UP]     = pen_evt_i[1];
    set_v[BIT_PEN_DN_SLP] = pen_evt_i[2];
    set_v[BIT_SLEEP]      = pen_evt_i[3];
    clr_v                 = wr_sta ? wb : '0;
  end

  adc_irq_ctl #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i, .rst_ni,
    .set_i        (set_v),
    .clr_i        (clr_v),
    .mask_wr_i    (wr_msk),
    .mask_wdata_i (wb),
    .stat_o       (stat_q),
    .mask_o       (mask_q),
    .irq_o        (irq_o)
  );

  assign res_in = {bat_res_i, aux_res_i};

  adc_res_regs #(.N_RES(N_RES), .RES_W(RES_W)) u_res (
    .clk_i, .rst_ni,
    .load_i ({cmpl[ENG_BAT], cmpl[ENG_AUX]}),
    .res_i  (res_in),
    .res_o  (res_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      low_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        sel_q <= wb[1:0];
        low_q <= wb[BIT_LOWREF];
      end
      if (wr_ena) pd_q <= wb[BIT_PWR_DN];
    end
  end

  always_comb begin
    ena_rd              = '0;
    ena_rd[N_ENG-1:0]   = en_q;
    ena_rd[BIT_PWR_DN]  = pd_q;
    rdata_o = '0;
    unique case (addr_i)
      OFS_ENA: rdata_o[7:0] = ena_rd;
      OFS_CFG: begin
        rdata_o[1:0]        = sel_q;
        rdata_o[BIT_LOWREF] = low_q;
      end
      OFS_MSK: rdata_o[7:0] = mask_q;
      OFS_STA: rdata_o[7:0] = stat_q;
      OFS_BAT: rdata_o = {{PAD_W{1'b0}}, res_q[ENG_BAT]};
      OFS_AUX: rdata_o = {{PAD_W{1'b0}}, res_q[ENG_AUX]};
      default: rdata_o = '0;
    endcase
  end

  assign aux_sel_o    = sel_q;
  assign bat_lowref_o = low_q;
  assign pwr_down_o   = pd_q;
endmodule

// File: rtl/adc_ctl_regs_chk.sv
module adc_ctl_regs_chk
  import adc_ctl_pkg::*;
#(
  parameter int unsigned N_ENG = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic                  wr_en_i,
  input logic [3:0]            wr_be_i,
  input logic [31:0]           wdata_i,
  input logic [N_ENG-1:0]      eng_start_o,
  input logic [N_ENG-1:0]      eng_done_i,
  input logic                  irq_o,
  input logic [N_ENG-1:0]      en_q,
  input logic [IRQ_W-1:0]      stat_q,
  input logic [IRQ_W-1:0]      mask_q
);
  logic             ena_wr;
  logic [N_ENG-1:0] acc, kill;
  assign ena_wr = wr_en_i && wr_be_i[0] && (addr_i == OFS_ENA);
  assign acc    = ena_wr ? (en_q & eng_done_i & wdata_i[N_ENG-1:0]) : (en_q & eng_done_i);
  assign kill   = ena_wr ? (en_q & ~wdata_i[N_ENG-1:0]) : '0;

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_start_o) |-> ((eng_start_o & en_q) == eng_start_o));

  p_start_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_start_o) |=> ((eng_start_o & $past(eng_start_o)) == '0));

  p_done_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acc) |=> ((en_q & $past(acc)) == '0));

  // also covers a same-cycle software clear (R6)
  p_done_sets_stat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acc) |=> ((stat_q[N_ENG-1:0] & $past(acc)) == $past(acc)));

  p_bit6_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[6]);

  p_abort_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|kill) |=> ((stat_q[N_ENG-1:0] & ~$past(stat_q[N_ENG-1:0]) & $past(kill)) == '0));

  p_full_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
endmodule

bind adc_ctl_regs adc_ctl_regs_chk #(.N_ENG(N_ENG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wr_be_i     (wr_be_i),
  .wdata_i     (wdata_i),
  .eng_start_o (eng_start_o),
  .eng_done_i  (eng_done_i),
  .irq_o       (irq_o),
  .en_q        (en_q),
  .stat_q      (stat_q),
  .mask_q      (mask_q)
);

// File: tb/adc_ctl_regs_bench.sv
`timescale 1ns/1ps
module adc_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [2:0]  start;
  logic [2:0]  done = '0;
  logic [11:0] aux_res = '0, bat_res = '0;
  logic [3:0]  pen = '0;
  logic [1:0]  aux_sel;
  logic        lowref, pdown;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_ctl_regs u_adc_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wr_be_i(be),
    .wdata_i(wd), .rdata_o(rdata), .irq_o(irq), .eng_start_o(start),
    .eng_done_i(done), .aux_res_i(aux_res), .bat_res_i(bat_res),
    .pen_evt_i(pen), .aux_sel_o(aux_sel), .bat_lowref_o(lowref),
    .pwr_down_o(pdown)
  );

  // behavioural reference model
  logic [2:0] m_en, m_start;
  logic [7:0] m_stat, m_mask;
  logic [1:0] m_sel;
  logic       m_low, m_pd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_start = 0; m_stat = 0; m_mask = 8'hFF; m_sel = 0; m_low = 0; m_pd = 0;
    end else begin
      automatic bit lane = wr && be[0];
      automatic bit ew = lane && addr == 6'h00;
      automatic logic [2:0] acc = 0;
      automatic logic [7:0] setb = 0;
      automatic logic [7:0] clrb = (lane && addr == 6'h0C) ? wd[7:0] : 8'h00;
      for (int i = 0; i < 3; i++)
        acc[i] = m_en[i] && done[i] && !(ew && !wd[i]);
      setb = {pen[3], 1'b0, pen[2:0], acc};
      m_start = ew ? (wd[2:0] & ~m_en) : 3'b000;
      if (ew) begin m_en = wd[2:0]; m_pd = wd[7]; end
      m_en = m_en & ~acc;
      m_stat = (m_stat & ~clrb) | setb;
      if (lane && addr == 6'h08) m_mask = wd[7:0];
      if (lane && addr == 6'h04) begin m_sel = wd[1:0]; m_low = wd[4]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every clock: outputs against the model
  always @(negedge clk) if (!finished) begin
    chk(irq === |(m_stat & ~m_mask), "R7 irq", {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
    chk(start === m_start, "R2 start", {29'b0, start}, {29'b0, m_start});
    chk({aux_sel, lowref, pdown} === {m_sel, m_low, m_pd}, "R9 cfg outs",
        {28'b0, aux_sel, lowref, pdown}, {28'b0, m_sel, m_low, m_pd});
  end

  task automatic cyc(input bit w, input logic [5:0] a, input logic [31:0] d,
                     input logic [3:0] b, input logic [2:0] dn, input logic [3:0] ev);
    @(negedge clk);
    wr = w; addr = a; wd = d; be = b; done = dn; pen = ev;
    @(negedge clk);
    wr = 0; wd = 0; be = 0; done = 0; pen = 0;
  endtask

  task automatic wrr(input logic [5:0] a, input logic [31:0] d);
    cyc(1, a, d, 4'h1, 3'b000, 4'h0);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h00, 0, "R1 enable"); rd(6'h04, 0, "R1 config"); rd(6'h08, 32'hFF, "R1 mask");
    rd(6'h0C, 0, "R1 status"); rd(6'h1C, 0, "R1 bat"); rd(6'h20, 0, "R1 aux");
    chk(irq === 0 && start === 0 && pdown === 0, "R1 outputs", {29'b0, irq, pdown, |start}, 0);

    // R2/R3/R4/R5 aux conversion
    wrr(6'h00, 32'h1);
    chk(start === 3'b001, "R2 aux start pulse", {29'b0, start}, 1);
    rd(6'h00, 1, "R2 enable set");
    aux_res = 12'hABC;
    cyc(0, 0, 0, 0, 3'b001, 0);
    rd(6'h00, 0, "R3 self clear"); rd(6'h0C, 1, "R4 aux status");
    rd(6'h20, 32'hABC, "R5 aux data");
    chk(irq === 0, "R7 masked at reset", {31'b0, irq}, 0);

    // R7/R6 mask and clear
    wrr(6'h08, 32'hFE);
    chk(irq === 1, "R7 unmasked irq", {31'b0, irq}, 1);
    wrr(6'h0C, 32'h01);
    rd(6'h0C, 0, "R6 w1c"); chk(irq === 0, "R6 irq drops", {31'b0, irq}, 0);

    // battery with full-word write
    cyc(1, 6'h00, 32'h2, 4'hF, 0, 0);
    rd(6'h00, 2, "R2 bat enable");
    bat_res = 12'hFFF;
    cyc(0, 0, 0, 0, 3'b010, 0);
    rd(6'h1C, 32'hFFF, "R5 bat data"); rd(6'h0C, 2, "R4 bat status");
    // R3 done on idle engine ignored
    bat_res = 12'h123;
    cyc(0, 0, 0, 0, 3'b010, 0);
    rd(6'h1C, 32'hFFF, "R3 idle done no latch"); rd(6'h0C, 2, "R3 idle done no status");
    wrr(6'h0C, 32'hFF);
    rd(6'h0C, 0, "R6 clear all");

    // R8 abort, then done later; abort with done same cycle
    wrr(6'h00, 32'h4);
    wrr(6'h00, 32'h0);
    cyc(0, 0, 0, 0, 3'b100, 0);
    rd(6'h0C, 0, "R8 abort no status"); rd(6'h00, 0, "R8 abort cleared");
    wrr(6'h00, 32'h1);
    aux_res = 12'h777;
    cyc(1, 6'h00, 32'h0, 4'h1, 3'b001, 0);
    rd(6'h0C, 0, "R8 same-cycle abort"); rd(6'h20, 32'hABC, "R8 no latch");

    // R6 hardware set beats same-cycle clear
    wrr(6'h00, 32'h1);
    aux_res = 12'h055;
    cyc(0, 0, 0, 0, 3'b001, 0);
    wrr(6'h00, 32'h1);
    cyc(1, 6'h0C, 32'h01, 4'h1, 3'b001, 0);
    rd(6'h0C, 1, "R6 set wins"); rd(6'h20, 32'h055, "R5 aux data 2");
    wrr(6'h0C, 32'hFF);

    // R4 pen events, R7 touch-only mask
    cyc(0, 0, 0, 0, 0, 4'hF);
    rd(6'h0C, 32'hB8, "R4 pen bits");
    wrr(6'h08, 32'hFB);
    chk(irq === 0, "R7 pen masked", {31'b0, irq}, 0);
    wrr(6'h00, 32'h4);
    cyc(0, 0, 0, 0, 3'b100, 0);
    rd(6'h0C, 32'hBC, "R4 touch status");
    chk(irq === 1, "R7 touch irq", {31'b0, irq}, 1);
    wrr(6'h0C, 32'h04);
    chk(irq === 0, "R7 touch cleared", {31'b0, irq}, 0);
    wrr(6'h0C, 32'hFF);

    // R9 config and power-down
    cyc(1, 6'h04, 32'hFFFFFFF2, 4'hF, 0, 0);
    rd(6'h04, 32'h12, "R9 config readback");
    chk(aux_sel === 2 && lowref === 1, "R9 config outs", {29'b0, aux_sel, lowref}, 32'h5);
    wrr(6'h00, 32'h80);
    chk(pdown === 1 && start === 0, "R9 pd no start", {30'b0, pdown, |start}, 2);
    wrr(6'h00, 32'h81);
    aux_res = 12'h300;
    cyc(0, 0, 0, 0, 3'b001, 0);
    rd(6'h00, 32'h80, "R9 pd independent");
    wrr(6'h00, 32'h0);

    // R10 byte lanes
    cyc(1, 6'h00, 32'h01, 4'b0010, 0, 0);
    rd(6'h00, 0, "R10 lane ignored");
    chk(start === 0, "R10 no start", {29'b0, start}, 0);

    // R5 data registers read-only
    cyc(1, 6'h20, 32'hFFFF, 4'hF, 0, 0);
    rd(6'h20, 32'h300, "R5 aux write ignored");
    cyc(1, 6'h1C, 32'h0, 4'hF, 0, 0);
    rd(6'h1C, 32'hFFF, "R5 bat write ignored");

    // R2 rewrite of busy bit gives no pulse
    wrr(6'h00, 32'h1);
    wrr(6'h00, 32'h1);
    chk(start === 0, "R2 no repeat pulse", {29'b0, start}, 0);
    cyc(0, 0, 0, 0, 3'b001, 0);
    rd(6'h00, 0, "R3 final clear");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule